// File: doc/BRIEF.md
# Saturating Push-Button Duty Setpoint Counter

This block holds the duty setpoint that a downstream PWM generator turns into a switching waveform. Two push buttons adjust it. One raises the setpoint and the other lowers it. A button takes effect once per press, at the moment it is let go, and holding a button down does nothing. The setpoint is clamped at both ends, so it never wraps from the bottom to the top or from the top to the bottom.

Each raw button level first passes through a two-flop synchroniser. It then passes a stable-sample filter, which accepts a new level only after that level has held for a set number of consecutive clocks. A release is the filtered level falling from pressed to not pressed. The setpoint then moves by one step.

The setpoint is 4 bits wide. Eight equal steps span 0% to 100% duty, so code 8 is full duty. The upper stop is code 9, the code with bit 0 and bit 3 both set, and a PWM stage reads code 9 as full duty too. Two flags report that the setpoint is at its upper stop or at zero.

Top module: `duty_setpoint_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `duty_set` is 0, `stop_dn` is 1 and `stop_up` is 0.
- R2: A filtered release of the up button raises `duty_set` by exactly one. A press on its own, or a button held down, leaves `duty_set` unchanged.
- R3: A filtered release of the down button lowers `duty_set` by exactly one.
- R4: When `duty_set` equals 9 (4'b1001: bit 0 and bit 3 set), `stop_up` is 1 and further up releases leave `duty_set` at 9. `stop_up` is 0 for every other value.
- R5: When `duty_set` is 0, `stop_dn` is 1 and further down releases leave it at 0. It never takes the value 15. `stop_dn` is 0 for every other value.
- R6: If the up and down releases are accepted on the same clock, `duty_set` does not change.
- R7: A raw button level is accepted only after the synchronised level has held for `STABLE_CYCLES` consecutive clocks. Pulses and bounces shorter than that are ignored.
- R8: `duty_set` changes on the (`STABLE_CYCLES`+3)-th rising clock edge after the raw button level changes to released, and not on any earlier edge.
- R9: `duty_set` changes by at most one per clock, and only in the cycle after a release was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_up_raw | input | 1 | Raw level of the raise button (1 = pressed by default) |
| btn_dn_raw | input | 1 | Raw level of the lower button (1 = pressed by default) |
| duty_set | output | CNT_W | Current duty setpoint, 0 to TOP_CODE |
| stop_up | output | 1 | Setpoint is at its upper stop |
| stop_dn | output | 1 | Setpoint is at zero |

## Verification
A raw release reaches `duty_set` on the (`STABLE_CYCLES`+3)-th rising edge. Two of those edges are the synchroniser, `STABLE_CYCLES` edges are the filter run, and one edge is the counter update. The flags follow `duty_set` in the same cycle. The bench drives inputs and samples outputs on the falling clock edge. For R8 it counts exactly one edge short of the due edge and then the due edge itself. Every other check waits a fixed margin past the due edge before it compares against the value it works out arithmetically.

// File: rtl/duty_sp_pkg.sv
package duty_sp_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  localparam int unsigned BTN_UP = 0;
  localparam int unsigned BTN_DN = 1;
  localparam int unsigned BTN_N  = 2;

  // Resolve one clock's requests into a single step, honouring the stops.
  function automatic step_e resolve_step(input logic up_req, input logic dn_req,
                                         input logic at_top, input logic at_bottom);
    step_e s;
    s = STEP_HOLD;
    if (up_req && !dn_req && !at_top)    s = STEP_UP;
    if (dn_req && !up_req && !at_bottom) s = STEP_DOWN;
    return s;
  endfunction

endpackage

// File: rtl/btn_sync_filter.sv
module btn_sync_filter #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned STABLE_CYCLES = 16,
  parameter bit          ACTIVE_HIGH   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic released
);
  localparam int unsigned RUN_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(STABLE_CYCLES - 1);
  localparam logic IDLE_LVL = ACTIVE_HIGH ? 1'b0 : 1'b1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic                   pressed_q;
  logic [RUN_W-1:0]       run_q;
  logic                   rel_q;
  logic                   synced_pressed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_LVL}};
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  assign synced         = sync_q[SYNC_STAGES-1];
  assign synced_pressed = ACTIVE_HIGH ? synced : ~synced;

  // Stable-sample filter: a differing level must persist STABLE_CYCLES clocks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pressed_q <= 1'b0;
      run_q     <= '0;
      rel_q     <= 1'b0;
    end else begin
      rel_q <= 1'b0;
      if (synced_pressed == pressed_q) begin
        run_q <= '0;
      end else if (run_q == RUN_LAST) begin
        run_q     <= '0;
        pressed_q <= synced_pressed;
        rel_q     <= pressed_q & ~synced_pressed;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign level    = pressed_q;
  assign released = rel_q;

endmodule

// File: rtl/setpoint_counter.sv
module setpoint_counter
  import duty_sp_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned TOP_CODE = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_req,
  input  logic             dec_req,
  output logic [CNT_W-1:0] value,
  output logic             at_top,
  output logic             at_bottom
);
  localparam logic [CNT_W-1:0] TOP_V = CNT_W'(TOP_CODE);

  logic [CNT_W-1:0] value_q;
  step_e            step;

  assign at_top    = (value_q == TOP_V);
  assign at_bottom = (value_q == '0);
  assign step      = resolve_step(inc_req, dec_req, at_top, at_bottom);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
    end else begin
      unique case (step)
        STEP_UP:   value_q <= value_q + 1'b1;
        STEP_DOWN: value_q <= value_q - 1'b1;
        default:   value_q <= value_q;
      endcase
    end
  end

  assign value = value_q;

endmodule

// File: rtl/duty_setpoint_ctrl.sv
module duty_setpoint_ctrl
  import duty_sp_pkg::*;
#(
  parameter int unsigned CNT_W         = 4,
  parameter int unsigned TOP_CODE      = 9,
  parameter int unsigned STABLE_CYCLES = 16,
  parameter bit          ACTIVE_HIGH   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_up_raw,
  input  logic             btn_dn_raw,
  output logic [CNT_W-1:0] duty_set,
  output logic             stop_up,
  output logic             stop_dn
);
  logic [BTN_N-1:0] raw_vec;
  logic [BTN_N-1:0] lvl_vec;
  logic [BTN_N-1:0] rel_vec;
  logic             rel_up;
  logic             rel_dn;

  assign raw_vec[BTN_UP] = btn_up_raw;
  assign raw_vec[BTN_DN] = btn_dn_raw;

  for (genvar b = 0; b < BTN_N; b++) begin : g_btn
    btn_sync_filter #(
      .SYNC_STAGES  (2),
      .STABLE_CYCLES(STABLE_CYCLES),
      .ACTIVE_HIGH  (ACTIVE_HIGH)
    ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (raw_vec[b]),
      .level   (lvl_vec[b]),
      .released(rel_vec[b])
    );
  end

  assign rel_up = rel_vec[BTN_UP];
  assign rel_dn = rel_vec[BTN_DN];

  setpoint_counter #(
    .CNT_W   (CNT_W),
    .TOP_CODE(TOP_CODE)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_req  (rel_up),
    .dec_req  (rel_dn),
    .value    (duty_set),
    .at_top   (stop_up),
    .at_bottom(stop_dn)
  );

endmodule

// File: rtl/duty_setpoint_checker.sv
module duty_setpoint_checker #(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned TOP_CODE = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] duty_set,
  input logic             stop_up,
  input logic             stop_dn,
  input logic             rel_up,
  input logic             rel_dn
);
  localparam logic [CNT_W-1:0] TOP_V = CNT_W'(TOP_CODE);

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (duty_set == '0 && stop_dn && !stop_up));

  assert_rise_needs_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_set > $past(duty_set)) |-> ($past(rel_up) && !$past(rel_dn)));

  assert_fall_needs_dn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_set < $past(duty_set)) |-> ($past(rel_dn) && !$past(rel_up)));

  assert_hold_at_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_up |=> (duty_set <= TOP_V));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_dn |=> (duty_set != {CNT_W{1'b1}}));

  assert_both_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_up && rel_dn) |=> $stable(duty_set));

  assert_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_set != $past(duty_set)) |->
      (duty_set == $past(duty_set) + 1'b1 || duty_set == $past(duty_set) - 1'b1));

  assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    duty_set <= TOP_V);

endmodule

bind duty_setpoint_ctrl duty_setpoint_checker #(
  .CNT_W   (CNT_W),
  .TOP_CODE(TOP_CODE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .duty_set(duty_set),
  .stop_up (stop_up),
  .stop_dn (stop_dn),
  .rel_up  (rel_up),
  .rel_dn  (rel_dn)
);

// File: tb/test_duty_setpoint_ctrl.sv
`timescale 1ns/1ps
module test_duty_setpoint_ctrl;
  localparam int N   = 4;
  localparam int TOP = 9;
  localparam int LAT = N + 3;
  localparam int GAP = N + 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       up_raw, dn_raw;
  logic [3:0] duty;
  logic       s_up, s_dn;
  int         n_chk = 0;
  int         n_bad = 0;
  int         exp_v;

  always #5 clk = ~clk;

  duty_setpoint_ctrl #(.CNT_W(4), .TOP_CODE(TOP), .STABLE_CYCLES(N), .ACTIVE_HIGH(1'b1))
    i_duty_setpoint_ctrl (
      .clk(clk), .rst_n(rst_n), .btn_up_raw(up_raw), .btn_dn_raw(dn_raw),
      .duty_set(duty), .stop_up(s_up), .stop_dn(s_dn));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_state(input string req, input int e);
    chk(duty == 4'(e), req, int'(duty), e);
    chk(s_up == (e == TOP), {req, " stop_up"}, int'(s_up), int'(e == TOP));
    chk(s_dn == (e == 0), {req, " stop_dn"}, int'(s_dn), int'(e == 0));
  endtask

  task automatic tap(input bit is_up);
    if (is_up) up_raw = 1'b1; else dn_raw = 1'b1;
    edges(GAP);
    if (is_up) up_raw = 1'b0; else dn_raw = 1'b0;
    edges(GAP);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; up_raw = 1'b0; dn_raw = 1'b0;
    edges(3);
    chk_state("R1 in reset", 0);
    rst_n = 1'b1;
    edges(1);
    chk_state("R1 after reset", 0);

    // R5: lowering at zero is ignored
    tap(1'b0);
    chk_state("R5 down at zero", 0);

    // R2: press only, held long, no change
    up_raw = 1'b1;
    edges(3 * GAP);
    chk_state("R2 held press", 0);
    // R8: exact latency from raw release
    up_raw = 1'b0;
    edges(LAT - 1);
    chk(duty == 4'd0, "R8 before due edge", int'(duty), 0);
    edges(1);
    chk(duty == 4'd1, "R8 at due edge", int'(duty), 1);
    edges(GAP);
    exp_v = 1;

    // R2/R4: sweep upward past the stop
    for (int k = 0; k < 11; k++) begin
      tap(1'b1);
      exp_v = (exp_v + 1 > TOP) ? TOP : exp_v + 1;
      chk_state((exp_v == TOP) ? "R4 up sweep" : "R2 up sweep", exp_v);
    end

    // R6: both released on the same clock at top, then mid-range
    up_raw = 1'b1; dn_raw = 1'b1; edges(GAP);
    up_raw = 1'b0; dn_raw = 1'b0; edges(GAP);
    chk_state("R6 both at top", exp_v);

    // R3/R5: sweep downward past zero
    for (int k = 0; k < 12; k++) begin
      tap(1'b0);
      exp_v = (exp_v - 1 < 0) ? 0 : exp_v - 1;
      chk_state((exp_v == 0) ? "R5 down sweep" : "R3 down sweep", exp_v);
      chk(duty != 4'd15, "R5 no wrap", int'(duty), exp_v);
    end

    tap(1'b1); tap(1'b1); tap(1'b1);
    exp_v = 3;
    chk_state("R2 climb to 3", exp_v);
    up_raw = 1'b1; dn_raw = 1'b1; edges(GAP);
    up_raw = 1'b0; dn_raw = 1'b0; edges(GAP);
    chk_state("R6 both mid", exp_v);

    // R7: short glitch (N-2 clocks) ignored
    up_raw = 1'b1; edges(N - 2);
    up_raw = 1'b0; edges(GAP);
    chk_state("R7 short glitch", exp_v);

    // R7: bouncy release gives a single step
    dn_raw = 1'b1; edges(GAP);
    dn_raw = 1'b0; edges(N - 2);
    dn_raw = 1'b1; edges(N - 2);
    chk_state("R7 bounce before final release", exp_v);
    dn_raw = 1'b0; edges(GAP);
    exp_v = exp_v - 1;
    chk_state("R7 bouncy release one step", exp_v);

    // R9: a single release moves by exactly one
    tap(1'b1);
    exp_v = exp_v + 1;
    chk_state("R9 single step", exp_v);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule